// File: doc/BRIEF.md
# Packet Header Inserting Stream Merger

This block gathers four 32-bit valid/ready input streams into one packet-switched output stream. Each output packet opens with a 32-bit routing header that the block builds itself. The header carries a 5-bit identifier chosen per input channel, a 3-bit packet type, a source-coordinate field fixed at all ones (meaning -1, the block's own origin) and an odd-parity bit. A fixed burst of payload words taken from that channel follows the header.

A start pulse loads a round count. The block then serves channel 0, 1, 2 and 3 in turn and repeats that rotation for the loaded number of rounds. When the final payload beat of the last round has been accepted, it raises a done flag. The identifiers and the packet type are plain configuration inputs. They are sampled whenever a header is presented.

Back-pressure follows the valid/ready rule on both sides. A beat moves only in a cycle where both valid and ready are high. While the output is stalled, its word is held unchanged. Payload is passed through without buffering: the selected input sees the output's ready, and every other input sees ready low.

Top module: `stream_header_merger`

## Requirements
- R1: After reset, `m_valid`, every bit of `s_ready` and `done` are low.
- R2: Header word layout: bits [4:0] hold the identifier of the channel being served (taken from `chan_id[5*c+4:5*c]` for channel c), bits [14:12] hold `pkt_type`, and bits [11:5], bit 15 and bits [30:28] are zero.
- R3: Bit 31 of every header makes the whole 32-bit word have an odd number of ones.
- R4: Header bits [20:16] (row) and [27:21] (column) are all ones, and `m_keep` is 4'hF on every beat.
- R5: Each packet is one header beat followed by 8 payload beats. `m_last` is high on the eighth payload beat only, and never on the header.
- R6: Channels are served in the order 0, 1, 2, 3, repeated for the number of rounds given on `round_cnt` at the start pulse. Payload of channel c is the words of `s_data[32*c+31:32*c]` in arrival order.
- R7: While `m_valid` is high and `m_ready` low, `m_valid`, `m_data` and `m_last` keep their values in the next cycle. No input word is dropped or duplicated.
- R8: An input handshake happens only on the channel being served, during its payload beats, and in the same cycle as an output handshake.
- R9: A start pulse clears `done`. `done` rises in the cycle after the last payload beat of the final round is accepted, and stays high with `m_valid` low until the next start. A start with `round_cnt` of 0 sets `done` at once and sends nothing.
- R10: A start pulse while a job is running is ignored: the running job ends after its original round count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a job when idle |
| round_cnt | input | ROUND_W | Number of full rotations, sampled at start |
| pkt_type | input | 3 | Packet type placed in every header |
| chan_id | input | 5*NUM_CH | Per-channel packet identifiers, channel c at [5c+4:5c] |
| s_valid | input | NUM_CH | Input word valid, one bit per channel |
| s_data | input | 32*NUM_CH | Input words, channel c at [32c+31:32c] |
| s_ready | output | NUM_CH | Input word accepted when high with valid |
| m_valid | output | 1 | Output beat valid |
| m_data | output | 32 | Output header or payload word |
| m_keep | output | 4 | Byte enables, all set |
| m_last | output | 1 | High on the final payload beat of a packet |
| m_ready | input | 1 | Downstream can accept a beat |
| done | output | 1 | Job finished |

## Verification
The stall-hold assertion relies on each upstream source keeping `s_valid` high and `s_data` unchanged until its word is taken. The bench respects this: it only draws a new random valid or word for a channel after that channel's handshake. The assertions also assume that `chan_id` and `pkt_type` do not change during a job. The bench sets them before each start pulse and leaves them alone. Valid and ready gaps are random with a fixed seed, and the directed jobs cover a zero round count, full-rate flow, heavy output stall and a start pulse inside a running job.

// File: rtl/shm_pkg.sv
package shm_pkg;
  localparam int WORD_W = 32;
  localparam int ID_W   = 5;
  localparam int TYPE_W = 3;
  localparam int KEEP_W = WORD_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_PAY  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/hdr_build.sv
module hdr_build
  import shm_pkg::*;
(
  input  logic [ID_W-1:0]   id_i,
  input  logic [TYPE_W-1:0] type_i,
  output logic [WORD_W-1:0] hdr_o
);
  logic [WORD_W-2:0] body;

  always_comb begin
    body        = '0;
    body[4:0]   = id_i;
    body[14:12] = type_i;
    body[20:16] = '1;   // origin row, -1
    body[27:21] = '1;   // origin column, -1
  end

  // top bit completes odd parity over the whole word
  assign hdr_o = {~(^body), body};
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import shm_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int PAYLOAD_LEN = 8,
  parameter int ROUND_W     = 8,
  localparam int SEL_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int BEAT_W     = (PAYLOAD_LEN > 1) ? $clog2(PAYLOAD_LEN) : 1
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [ROUND_W-1:0] rounds_i,
  input  logic               fire_i,
  output logic [SEL_W-1:0]   sel_o,
  output logic               hdr_o,
  output logic               pay_o,
  output logic               last_o,
  output logic               done_o
);
  seq_state_e         state_q;
  logic [SEL_W-1:0]   ch_q;
  logic [BEAT_W-1:0]  beat_q;
  logic [ROUND_W-1:0] round_q;
  logic [ROUND_W-1:0] rounds_q;
  logic               done_q;

  localparam logic [SEL_W-1:0]  LAST_CH   = SEL_W'(NUM_CH - 1);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(PAYLOAD_LEN - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ch_q     <= '0;
      beat_q   <= '0;
      round_q  <= '0;
      rounds_q <= '0;
      done_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          ch_q     <= '0;
          beat_q   <= '0;
          round_q  <= '0;
          rounds_q <= rounds_i;
          if (rounds_i == '0) begin
            done_q <= 1'b1;
          end else begin
            done_q  <= 1'b0;
            state_q <= ST_HDR;
          end
        end
        ST_HDR: if (fire_i) begin
          beat_q  <= '0;
          state_q <= ST_PAY;
        end
        ST_PAY: if (fire_i) begin
          if (beat_q == LAST_BEAT) begin
            beat_q <= '0;
            if (ch_q == LAST_CH) begin
              ch_q <= '0;
              if (round_q == rounds_q - 1'b1) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end else begin
                round_q <= round_q + 1'b1;
                state_q <= ST_HDR;
              end
            end else begin
              ch_q    <= ch_q + 1'b1;
              state_q <= ST_HDR;
            end
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sel_o  = ch_q;
  assign hdr_o  = (state_q == ST_HDR);
  assign pay_o  = (state_q == ST_PAY);
  assign last_o = (state_q == ST_PAY) && (beat_q == LAST_BEAT);
  assign done_o = done_q;

  // R5
  last_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && last_o) |=> (state_q != ST_PAY));

  // R9
  done_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (state_q == ST_IDLE));

  // R10
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && state_q != ST_IDLE) |=> $stable(rounds_q));

  // R5
  header_then_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && hdr_o) |=> (pay_o && beat_q == '0));
endmodule

// File: rtl/stream_header_merger.sv
module stream_header_merger
  import shm_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int PAYLOAD_LEN = 8,
  parameter int ROUND_W     = 8
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [ROUND_W-1:0]       round_cnt,
  input  logic [TYPE_W-1:0]        pkt_type,
  input  logic [ID_W*NUM_CH-1:0]   chan_id,
  input  logic [NUM_CH-1:0]        s_valid,
  input  logic [WORD_W*NUM_CH-1:0] s_data,
  output logic [NUM_CH-1:0]        s_ready,
  output logic                     m_valid,
  output logic [WORD_W-1:0]        m_data,
  output logic [KEEP_W-1:0]        m_keep,
  output logic                     m_last,
  input  logic                     m_ready,
  output logic                     done
);
  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [SEL_W-1:0]  sel;
  logic              hdr_ph;
  logic              pay_ph;
  logic              last_ph;
  logic              fire;
  logic [WORD_W-1:0] hdr_word;
  logic [WORD_W-1:0] lane_data [NUM_CH];
  logic [ID_W-1:0]   lane_id   [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    assign lane_data[g] = s_data[g*WORD_W +: WORD_W];
    assign lane_id[g]   = chan_id[g*ID_W +: ID_W];
    assign s_ready[g]   = pay_ph && m_ready && (sel == SEL_W'(g));
  end

  seq_ctrl #(
    .NUM_CH      (NUM_CH),
    .PAYLOAD_LEN (PAYLOAD_LEN),
    .ROUND_W     (ROUND_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .rounds_i (round_cnt),
    .fire_i   (fire),
    .sel_o    (sel),
    .hdr_o    (hdr_ph),
    .pay_o    (pay_ph),
    .last_o   (last_ph),
    .done_o   (done)
  );

  hdr_build u_hdr (
    .id_i   (lane_id[sel]),
    .type_i (pkt_type),
    .hdr_o  (hdr_word)
  );

  assign m_valid = hdr_ph | (pay_ph & s_valid[sel]);
  assign m_data  = hdr_ph ? hdr_word : lane_data[sel];
  assign m_last  = last_ph;
  assign m_keep  = '1;
  assign fire    = m_valid && m_ready;

  // R8
  one_input_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_ready));

  // R3
  header_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && hdr_ph) |-> ($countones(m_data) % 2 == 1));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

  // R5
  no_last_on_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_ph |-> !m_last);
endmodule

// File: tb/test_stream_header_merger.sv
module test_stream_header_merger;
  localparam int NCH = 4;
  localparam int LEN = 8;
  localparam int RW  = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n, start, m_valid, m_last, m_ready, done;
  logic [RW-1:0]    round_cnt;
  logic [2:0]       pkt_type;
  logic [5*NCH-1:0] chan_id;
  logic [NCH-1:0]   s_valid, s_ready;
  logic [32*NCH-1:0] s_data;
  logic [31:0]      m_data;
  logic [3:0]       m_keep;

  stream_header_merger #(.NUM_CH(NCH), .PAYLOAD_LEN(LEN), .ROUND_W(RW)) i_stream_header_merger (
    .clk(clk), .rst_n(rst_n), .start(start), .round_cnt(round_cnt), .pkt_type(pkt_type),
    .chan_id(chan_id), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .m_valid(m_valid), .m_data(m_data), .m_keep(m_keep), .m_last(m_last),
    .m_ready(m_ready), .done(done));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int sent [NCH];
  int exp_seq [NCH];
  bit took [NCH];

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic logic [31:0] hdr_exp(logic [4:0] id, logic [2:0] t);
    logic [31:0] h = 32'h0;
    h[4:0]   = id;
    h[14:12] = t;
    h[20:16] = 5'h1f;
    h[27:21] = 7'h7f;
    h[31]    = ($countones(h) % 2 == 0);
    return h;
  endfunction

  function automatic logic [31:0] word_of(int c, int n);
    return {8'(8'hA0 + c), 24'(n)};
  endfunction

  task automatic step_inputs(int vpct, int rpct);
    for (int c = 0; c < NCH; c++) begin
      if (took[c]) sent[c]++;
      if (!s_valid[c] || took[c]) s_valid[c] = (($urandom % 100) < vpct);
      s_data[c*32 +: 32] = word_of(c, sent[c]);
      took[c] = 0;
    end
    m_ready = (($urandom % 100) < rpct);
  endtask

  task automatic run_job(int n, int vpct, int rpct, int inject_at, bit fixed_ids);
    int pos = 0, mch = 0, mround = 0, cyc = 0;
    bit fin = 0, stall = 0, fire_o, ok;
    logic [31:0] pd;
    logic pl;
    for (int c = 0; c < NCH; c++) begin
      chan_id[c*5 +: 5] = fixed_ids ? 5'(c) : 5'($urandom);
      took[c] = 0;
    end
    pkt_type = fixed_ids ? 3'd0 : 3'($urandom);
    @(negedge clk);
    start = 1; round_cnt = RW'(n);
    step_inputs(vpct, rpct);
    forever begin
      @(negedge clk);
      start = (cyc == inject_at);
      if (cyc == inject_at) round_cnt = RW'(n + 3);
      step_inputs(vpct, rpct);
      #1;
      if (cyc == 0) chk(done == 1'b0, "R9 done cleared by start", 32'(done), 0);
      if (fin) begin
        chk(done == 1'b1, "R9/R10 done after final round", 32'(done), 1);
        chk(m_valid == 1'b0, "R9 idle after done", 32'(m_valid), 0);
        for (int c = 0; c < NCH; c++)
          chk(sent[c] == exp_seq[c], "R7 no word dropped or duplicated", 32'(sent[c]), 32'(exp_seq[c]));
        break;
      end
      if (stall)
        chk(m_valid && m_data == pd && m_last == pl, "R7 stalled beat held", m_data, pd);
      fire_o = m_valid && m_ready;
      for (int c = 0; c < NCH; c++) begin
        took[c] = s_valid[c] && s_ready[c];
        if (took[c]) begin
          ok = (c == mch) && (pos > 0) && fire_o;
          chk(ok, "R8 input taken only on served channel", 32'(c), 32'(mch));
        end
      end
      if (fire_o) begin
        chk(m_keep == 4'hf, "R4 keep all set", 32'(m_keep), 32'hf);
        if (pos == 0) begin
          chk(m_data == hdr_exp(chan_id[mch*5 +: 5], pkt_type), "R2 header fields", m_data,
              hdr_exp(chan_id[mch*5 +: 5], pkt_type));
          chk($countones(m_data) % 2 == 1, "R3 header odd parity", m_data, 0);
          chk(m_data[27:16] == 12'hfff, "R4 source row/column all ones", 32'(m_data[27:16]), 32'hfff);
          chk(!m_last, "R5 header has last low", 32'(m_last), 0);
          if (fixed_ids && mch == 0)
            chk(m_data == 32'h8FFF0000, "R2 id0 type0 header value", m_data, 32'h8FFF0000);
        end else begin
          chk(m_data == word_of(mch, exp_seq[mch]), "R6 payload order from served channel", m_data,
              word_of(mch, exp_seq[mch]));
          exp_seq[mch]++;
          chk(m_last == (pos == LEN), "R5 last on eighth payload only", 32'(m_last), 32'(pos == LEN));
        end
        pos++;
        if (pos > LEN) begin
          pos = 0; mch++;
          if (mch == NCH) begin mch = 0; mround++; if (mround == n) fin = 1; end
        end
      end
      stall = m_valid && !m_ready;
      pd = m_data; pl = m_last;
      cyc++;
      if (cyc > 40000) begin
        chk(0, "R6 job did not finish", 32'(cyc), 0);
        break;
      end
    end
    start = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; start = 0; round_cnt = '0; pkt_type = '0; chan_id = '0;
    s_valid = '0; s_data = '0; m_ready = 0;
    for (int c = 0; c < NCH; c++) begin sent[c] = 0; exp_seq[c] = 0; took[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(m_valid == 0, "R1 m_valid low after reset", 32'(m_valid), 0);
    chk(s_ready == '0, "R1 s_ready low after reset", 32'(s_ready), 0);
    chk(done == 0, "R1 done low after reset", 32'(done), 0);

    // R9: zero rounds
    @(negedge clk); start = 1; round_cnt = '0; m_ready = 1;
    @(negedge clk); start = 0;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(done == 1, "R9 zero rounds sets done", 32'(done), 1);
      chk(m_valid == 0, "R9 zero rounds sends nothing", 32'(m_valid), 0);
      @(negedge clk);
    end

    run_job(1, 100, 100, -1, 1);   // full-rate directed
    run_job(2, 60, 60, 15, 0);     // R10 start while busy
    run_job(3, 30, 40, -1, 0);     // sparse random
    run_job(1, 100, 15, 5, 0);     // heavy stall, R7, R10
    run_job(2, 85, 90, -1, 0);
    finish_up();
  end
endmodule